// File: doc/BRIEF.md
# SDRAM Command Decoder and Legality Checker

This block watches the control pins of a four-bank synchronous DRAM on every rising clock edge. It turns each sample into one command, keeps a state for each bank (idle, open, closing after an auto-precharge burst, precharging), and reports the command, its bank, column and auto-precharge flag one cycle after the edge that sampled it. When the current state does not allow the command, it raises an illegal flag for that report cycle. An illegal command leaves every bank state untouched.

Clock-count rules come from parameters: the burst length, the row precharge time, the lockout after a mode-register write, and the read-mask latency. Two mask enables follow the data-mask pin. The write mask applies in the same cycle. The read high-impedance enable is delayed by the read-mask latency. The block is meant to sit beside a memory controller or a memory model as a protocol monitor.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With cke high on the previous and current sample and csN low, {rasN,casN,weN} decodes as 011 activate (code 7), 101 read (8), 100 write (9), 110 burst stop (10), 010 precharge (11 with a10 low, 12 with a10 high), 111 no operation (0). cmdCode shows the command from edge k after edge k.
- R2: csN high decodes as deselect (code 1). cke low on both the previous and current sample decodes as no operation (0) whatever the other pins are, and it changes no bank state. Deselect and no operation are never illegal.
- R3: Pins 000 decode as a mode register write: code 2 with ba[1] low, code 3 with ba[1] high. It is illegal unless every bank is idle.
- R4: After a legal mode register write at edge k, any command other than no operation or deselect at edge k+1 is illegal (MRS_GAP=2). A command at edge k+2 is judged normally.
- R5: Pins 001 decode as auto refresh (4) when cke is high on both samples, and as self-refresh entry (5) when cke goes from high to low. When cke goes from low to high after a legal entry, the sample decodes as self-refresh exit (6). Refresh is illegal unless every bank is idle.
- R6: For activate, read, write and single-bank precharge, cmdBank reports {ba[1],ba[0]}. For read and write, cmdColumn reports col and cmdAutoPre reports a10. For every other command these three outputs are 0.
- R7: An activate to a bank that is not idle, or a read or write to a bank that is not open, is illegal. It leaves the bank state as it was.
- R8: A single-bank precharge at edge k closes that bank. An activate to it is illegal at edges before k+T_RP and legal at k+T_RP. A precharge with a10 high closes all banks and ignores ba; it reports cmdBank 0 and cmdAutoPre 1.
- R9: After a read or write with auto precharge to a bank at edge k, a read or write to that bank is illegal until the bank is opened again. An activate to it is illegal before edge k+BURST_LEN+T_RP and legal at that edge.
- R10: Burst stop is legal in every bank state and changes no bank state.
- R11: wrMaskEn equals dqm in the same cycle (write-mask latency 0).
- R12: For dqm sampled high at edge k, rdHiZEn is high from edge k+1 to edge k+2 (read-mask latency RD_MASK_LAT=2), so read data driven at edge k+2 is blanked.
- R13: During and right after reset, cmdCode is 0, cmdIllegal, wrMaskEn (with dqm low) and rdHiZEn are 0, and all banks are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock, rising edge samples |
| rstN | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable pin |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| ba | input | BANK_BITS | Bank address |
| a10 | input | 1 | Auto-precharge / all-bank select address bit |
| col | input | COL_BITS | Column address bits |
| dqm | input | 1 | Data mask pin |
| cmdCode | output | 4 | Decoded command code |
| cmdBank | output | BANK_BITS | Target bank of the reported command |
| cmdAutoPre | output | 1 | Auto-precharge or all-bank flag |
| cmdColumn | output | COL_BITS | Column of a reported read or write |
| cmdIllegal | output | 1 | Reported command not allowed in the current state |
| wrMaskEn | output | 1 | Write data mask enable, same cycle |
| rdHiZEn | output | 1 | Read data high-impedance enable, delayed |

## Verification
The bench builds the block with BURST_LEN=4 and T_RP=2. With these values, every boundary of the auto-precharge window and the precharge window is a few cycles from the command that opened it, so the bench can check the last illegal edge and the first legal edge for each. The mode-register lockout and the read-mask latency keep their default of 2. This lets the bench test the lockout edge and the edge just after it, and the two-cycle dqm delay.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [3:0] {
    CMD_NOP      = 4'd0,
    CMD_DESEL    = 4'd1,
    CMD_MRS      = 4'd2,
    CMD_EMRS     = 4'd3,
    CMD_AREF     = 4'd4,
    CMD_SREF_IN  = 4'd5,
    CMD_SREF_OUT = 4'd6,
    CMD_ACT      = 4'd7,
    CMD_RD       = 4'd8,
    CMD_WR       = 4'd9,
    CMD_BST      = 4'd10,
    CMD_PRE      = 4'd11,
    CMD_PREALL   = 4'd12
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE   = 2'd0,
    BK_OPEN   = 2'd1,
    BK_APBURST = 2'd2,
    BK_PRECH  = 2'd3
  } bank_e;

  // strobes from control to datapath, one set per sampled edge
  typedef struct packed {
    cmd_e cmd;
    logic illegal;
    logic useBank;
    logic useCol;
    logic useAp;
  } strobe_t;

endpackage

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
  import sdram_mon_pkg::*;
#(
  parameter int BURST_LEN = 8,
  parameter int T_RP      = 3
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  doAct,
  input  logic  doApBurst,
  input  logic  doPre,
  output bank_e state
);
  localparam int CNT_W = $clog2(BURST_LEN + T_RP + 1);
  localparam logic [CNT_W-1:0] LOAD_AP  = CNT_W'(BURST_LEN + T_RP - 1);
  localparam logic [CNT_W-1:0] LOAD_PRE = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] RP_LIM   = CNT_W'(T_RP);

  logic [CNT_W-1:0] cnt;

  // closing states follow the remaining count
  function automatic bank_e stateFor(input logic [CNT_W-1:0] c);
    if (c == '0)        return BK_IDLE;
    else if (c > RP_LIM) return BK_APBURST;
    else                return BK_PRECH;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= BK_IDLE;
      cnt   <= '0;
    end else if (doAct) begin
      state <= BK_OPEN;
      cnt   <= '0;
    end else if (doApBurst) begin
      state <= stateFor(LOAD_AP);
      cnt   <= LOAD_AP;
    end else if (doPre) begin
      state <= stateFor(LOAD_PRE);
      cnt   <= LOAD_PRE;
    end else if (state == BK_APBURST || state == BK_PRECH) begin
      state <= stateFor(cnt - 1'b1);
      cnt   <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/sdram_mon_ctrl.sv
module sdram_mon_ctrl
  import sdram_mon_pkg::*;
#(
  parameter int BANK_BITS = 2,
  parameter int BURST_LEN = 8,
  parameter int T_RP      = 3,
  parameter int MRS_GAP   = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cke,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic [BANK_BITS-1:0] ba,
  input  logic                 a10,
  output strobe_t              strobe
);
  localparam int NUM_BANKS = 1 << BANK_BITS;
  localparam int LOCK_W    = $clog2(MRS_GAP + 1);
  localparam logic [LOCK_W-1:0] LOCK_LOAD = LOCK_W'(MRS_GAP - 1);

  logic              ckePrev;
  logic              selfRef;
  logic [LOCK_W-1:0] lockCnt;
  cmd_e              rawCmd;
  logic              bad;
  logic              allIdle;
  logic              anyApBurst;
  bank_e             bankState [NUM_BANKS];
  logic [NUM_BANKS-1:0] doAct, doApBurst, doPre;

  // pin decode
  always_comb begin
    rawCmd = CMD_NOP;
    if (!ckePrev) begin
      rawCmd = (cke && selfRef) ? CMD_SREF_OUT : CMD_NOP;
    end else if (csN) begin
      rawCmd = CMD_DESEL;
    end else begin
      unique case ({rasN, casN, weN})
        3'b000: rawCmd = ba[BANK_BITS-1] ? CMD_EMRS : CMD_MRS;
        3'b001: rawCmd = cke ? CMD_AREF : CMD_SREF_IN;
        3'b011: rawCmd = CMD_ACT;
        3'b101: rawCmd = CMD_RD;
        3'b100: rawCmd = CMD_WR;
        3'b110: rawCmd = CMD_BST;
        3'b010: rawCmd = a10 ? CMD_PREALL : CMD_PRE;
        default: rawCmd = CMD_NOP;
      endcase
    end
  end

  always_comb begin
    allIdle    = 1'b1;
    anyApBurst = 1'b0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (bankState[i] != BK_IDLE)    allIdle    = 1'b0;
      if (bankState[i] == BK_APBURST) anyApBurst = 1'b1;
    end
  end

  // legality against bank state and lockout
  always_comb begin
    bad = 1'b0;
    if (lockCnt != '0 && rawCmd != CMD_NOP && rawCmd != CMD_DESEL) bad = 1'b1;
    case (rawCmd)
      CMD_MRS, CMD_EMRS, CMD_AREF, CMD_SREF_IN: if (!allIdle) bad = 1'b1;
      CMD_ACT:    if (bankState[ba] != BK_IDLE)    bad = 1'b1;
      CMD_RD, CMD_WR: if (bankState[ba] != BK_OPEN) bad = 1'b1;
      CMD_PRE:    if (bankState[ba] == BK_APBURST) bad = 1'b1;
      CMD_PREALL: if (anyApBurst)                  bad = 1'b1;
      default: ;
    endcase
  end

  generate
    for (genvar g = 0; g < NUM_BANKS; g++) begin : gBank
      logic hit;
      assign hit = (ba == BANK_BITS'(g)) && !bad;
      assign doAct[g]     = hit && rawCmd == CMD_ACT;
      assign doApBurst[g] = hit && a10 && (rawCmd == CMD_RD || rawCmd == CMD_WR);
      assign doPre[g]     = (!bad && rawCmd == CMD_PREALL) || (hit && rawCmd == CMD_PRE);

      sdram_bank_track #(.BURST_LEN(BURST_LEN), .T_RP(T_RP)) uTrack (
        .clk      (clk),
        .rstN     (rstN),
        .doAct    (doAct[g]),
        .doApBurst(doApBurst[g]),
        .doPre    (doPre[g]),
        .state    (bankState[g])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ckePrev <= 1'b1;
      selfRef <= 1'b0;
      lockCnt <= '0;
    end else begin
      ckePrev <= cke;
      if (rawCmd == CMD_SREF_IN && !bad) selfRef <= 1'b1;
      else if (rawCmd == CMD_SREF_OUT)   selfRef <= 1'b0;
      if ((rawCmd == CMD_MRS || rawCmd == CMD_EMRS) && !bad) lockCnt <= LOCK_LOAD;
      else if (lockCnt != '0)                                lockCnt <= lockCnt - 1'b1;
    end
  end

  always_comb begin
    strobe.cmd     = rawCmd;
    strobe.illegal = bad;
    strobe.useBank = rawCmd inside {CMD_ACT, CMD_RD, CMD_WR, CMD_PRE};
    strobe.useCol  = rawCmd inside {CMD_RD, CMD_WR};
    strobe.useAp   = rawCmd inside {CMD_RD, CMD_WR, CMD_PREALL};
  end

endmodule

// File: rtl/sdram_mon_path.sv
module sdram_mon_path
  import sdram_mon_pkg::*;
#(
  parameter int BANK_BITS   = 2,
  parameter int COL_BITS    = 8,
  parameter int RD_MASK_LAT = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobe,
  input  logic [BANK_BITS-1:0] ba,
  input  logic                 a10,
  input  logic [COL_BITS-1:0]  col,
  input  logic                 dqm,
  output logic [3:0]           cmdCode,
  output logic [BANK_BITS-1:0] cmdBank,
  output logic                 cmdAutoPre,
  output logic [COL_BITS-1:0]  cmdColumn,
  output logic                 cmdIllegal,
  output logic                 wrMaskEn,
  output logic                 rdHiZEn
);
  cmd_e cmdReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg     <= CMD_NOP;
      cmdBank    <= '0;
      cmdAutoPre <= 1'b0;
      cmdColumn  <= '0;
      cmdIllegal <= 1'b0;
    end else begin
      cmdReg     <= strobe.cmd;
      cmdIllegal <= strobe.illegal;
      cmdBank    <= strobe.useBank ? ba  : '0;
      cmdColumn  <= strobe.useCol  ? col : '0;
      cmdAutoPre <= strobe.useAp   ? a10 : 1'b0;
    end
  end

  assign cmdCode  = cmdReg;
  assign wrMaskEn = dqm;

  generate
    if (RD_MASK_LAT == 0) begin : gLat0
      assign rdHiZEn = dqm;
    end else if (RD_MASK_LAT == 1) begin : gLat1
      logic pipe;
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) pipe <= 1'b0;
        else       pipe <= dqm;
      assign rdHiZEn = pipe;
    end else begin : gLatN
      logic [RD_MASK_LAT-1:0] pipe;
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) pipe <= '0;
        else       pipe <= {pipe[RD_MASK_LAT-2:0], dqm};
      assign rdHiZEn = pipe[RD_MASK_LAT-1];
    end
  endgenerate

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int BANK_BITS   = 2,
  parameter int COL_BITS    = 8,
  parameter int BURST_LEN   = 8,
  parameter int T_RP        = 3,
  parameter int MRS_GAP     = 2,
  parameter int RD_MASK_LAT = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cke,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic [BANK_BITS-1:0] ba,
  input  logic                 a10,
  input  logic [COL_BITS-1:0]  col,
  input  logic                 dqm,
  output logic [3:0]           cmdCode,
  output logic [BANK_BITS-1:0] cmdBank,
  output logic                 cmdAutoPre,
  output logic [COL_BITS-1:0]  cmdColumn,
  output logic                 cmdIllegal,
  output logic                 wrMaskEn,
  output logic                 rdHiZEn
);
  strobe_t strobe;

  sdram_mon_ctrl #(
    .BANK_BITS(BANK_BITS), .BURST_LEN(BURST_LEN), .T_RP(T_RP), .MRS_GAP(MRS_GAP)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .ba(ba), .a10(a10), .strobe(strobe)
  );

  sdram_mon_path #(
    .BANK_BITS(BANK_BITS), .COL_BITS(COL_BITS), .RD_MASK_LAT(RD_MASK_LAT)
  ) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ba(ba), .a10(a10), .col(col),
    .dqm(dqm), .cmdCode(cmdCode), .cmdBank(cmdBank), .cmdAutoPre(cmdAutoPre),
    .cmdColumn(cmdColumn), .cmdIllegal(cmdIllegal), .wrMaskEn(wrMaskEn),
    .rdHiZEn(rdHiZEn)
  );

endmodule

// File: rtl/sdram_mon_checker.sv
module sdram_mon_checker #(
  parameter int BANK_BITS   = 2,
  parameter int MRS_GAP     = 2,
  parameter int RD_MASK_LAT = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 dqm,
  input logic [3:0]           cmdCode,
  input logic [BANK_BITS-1:0] cmdBank,
  input logic                 cmdAutoPre,
  input logic                 cmdIllegal,
  input logic                 rdHiZEn
);
  logic okRdWr, okAct;
  assign okRdWr = (cmdCode == 4'd8 || cmdCode == 4'd9) && !cmdIllegal;
  assign okAct  = (cmdCode == 4'd7) && !cmdIllegal;

  AST_IDLE_NEVER_ILLEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (cmdCode == 4'd0 || cmdCode == 4'd1) |-> !cmdIllegal); // R2

  AST_ACT_REOPEN: assert property (@(posedge clk) disable iff (!rstN)
    okAct |=> !(okAct && cmdBank == $past(cmdBank))); // R7

  AST_PREALL_FIELDS: assert property (@(posedge clk) disable iff (!rstN)
    (cmdCode == 4'd12) |-> (cmdBank == '0 && cmdAutoPre)); // R8

  AST_AP_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (okRdWr && cmdAutoPre) |=> !(okRdWr && cmdBank == $past(cmdBank))); // R9

  generate
    if (MRS_GAP >= 2) begin : gLock
      AST_MRS_LOCKOUT: assert property (@(posedge clk) disable iff (!rstN)
        ((cmdCode == 4'd2 || cmdCode == 4'd3) && !cmdIllegal)
        |=> (cmdCode == 4'd0 || cmdCode == 4'd1 || cmdIllegal)); // R4
    end
    if (RD_MASK_LAT == 2) begin : gRdLat
      AST_RD_HIZ_LAT: assert property (@(posedge clk) disable iff (!rstN)
        rdHiZEn |-> $past(dqm, 2)); // R12
    end
  endgenerate

endmodule

bind sdram_cmd_monitor sdram_mon_checker #(
  .BANK_BITS(BANK_BITS), .MRS_GAP(MRS_GAP), .RD_MASK_LAT(RD_MASK_LAT)
) uChk (
  .clk(clk), .rstN(rstN), .dqm(dqm), .cmdCode(cmdCode), .cmdBank(cmdBank),
  .cmdAutoPre(cmdAutoPre), .cmdIllegal(cmdIllegal), .rdHiZEn(rdHiZEn)
);

// File: tb/sim_sdram_cmd_monitor.sv
module sim_sdram_cmd_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int BL = 4;
  localparam int TRP = 2;

  localparam logic [2:0] P_MRS = 3'b000, P_REF = 3'b001, P_ACT = 3'b011,
                         P_RD  = 3'b101, P_WR  = 3'b100, P_BST = 3'b110,
                         P_PRE = 3'b010, P_NOP = 3'b111;

  logic clk = 1'b0, rstN = 1'b0;
  logic cke = 1'b1, csN = 1'b0, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [1:0] ba = '0;
  logic a10 = 1'b0, dqm = 1'b0;
  logic [7:0] col = '0;
  logic [3:0] cmdCode;
  logic [1:0] cmdBank;
  logic cmdAutoPre, cmdIllegal, wrMaskEn, rdHiZEn;
  logic [7:0] cmdColumn;
  int nChecks = 0, nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_monitor #(.BURST_LEN(BL), .T_RP(TRP)) u0 (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .ba(ba), .a10(a10), .col(col), .dqm(dqm), .cmdCode(cmdCode),
    .cmdBank(cmdBank), .cmdAutoPre(cmdAutoPre), .cmdColumn(cmdColumn),
    .cmdIllegal(cmdIllegal), .wrMaskEn(wrMaskEn), .rdHiZEn(rdHiZEn)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // drive one command (csN low), step one edge, check code and illegal flag
  task automatic issue(input string tag, input logic [2:0] rcw, input logic [1:0] b,
                       input logic ap, input int expCode, input int expIll);
    csN = 1'b0; {rasN, casN, weN} = rcw; ba = b; a10 = ap;
    step();
    check({tag, " code"}, cmdCode, expCode);
    check({tag, " illegal"}, cmdIllegal, expIll);
    {rasN, casN, weN} = P_NOP; a10 = 1'b0;
  endtask

  task automatic closeAll();
    issue("R8 cleanup prech-all", P_PRE, 2'd0, 1'b1, 12, 0);
    issue("R2 nop", P_NOP, 2'd0, 1'b0, 0, 0);
    issue("R2 nop", P_NOP, 2'd0, 1'b0, 0, 0);
  endtask

  task automatic t_reset();
    check("R13 reset code", cmdCode, 0);
    check("R13 reset illegal", cmdIllegal, 0);
    check("R13 reset rdHiZ", rdHiZEn, 0);
    check("R13 reset wrMask", wrMaskEn, 0);
  endtask

  task automatic t_decode();
    issue("R1 act b2", P_ACT, 2'd2, 1'b0, 7, 0);
    check("R6 act bank", cmdBank, 2);
    col = 8'h5A;
    issue("R1 read b2", P_RD, 2'd2, 1'b0, 8, 0);
    check("R6 read bank", cmdBank, 2);
    check("R6 read column", cmdColumn, 8'h5A);
    check("R6 read ap", cmdAutoPre, 0);
    col = 8'hC3;
    issue("R1 write b2", P_WR, 2'd2, 1'b0, 9, 0);
    check("R6 write column", cmdColumn, 8'hC3);
    issue("R10 burst stop", P_BST, 2'd2, 1'b0, 10, 0);
    check("R6 bst bank zero", cmdBank, 0);
    csN = 1'b1; step();
    check("R2 deselect code", cmdCode, 1);
    check("R2 deselect legal", cmdIllegal, 0);
    issue("R7 act open bank", P_ACT, 2'd2, 1'b0, 7, 1);
    issue("R7 read closed bank", P_RD, 2'd1, 1'b0, 8, 1);
    issue("R7 r10_ b2 still open", P_RD, 2'd2, 1'b0, 8, 0);
    issue("R8 prech-all", P_PRE, 2'd3, 1'b1, 12, 0);
    check("R8 prech-all bank", cmdBank, 0);
    check("R8 prech-all ap", cmdAutoPre, 1);
    issue("R2 nop", P_NOP, 2'd0, 1'b0, 0, 0);
    issue("R2 nop", P_NOP, 2'd0, 1'b0, 0, 0);
  endtask

  task automatic t_precharge();
    issue("R8 act b2", P_ACT, 2'd2, 1'b0, 7, 0);
    issue("R8 prech b2", P_PRE, 2'd2, 1'b0, 11, 0);
    check("R8 prech bank", cmdBank, 2);
    issue("R8 act before tRP", P_ACT, 2'd2, 1'b0, 7, 1);
    issue("R8 act at tRP", P_ACT, 2'd2, 1'b0, 7, 0);
    closeAll();
  endtask

  task automatic t_mrs();
    issue("R3 act b0", P_ACT, 2'd0, 1'b0, 7, 0);
    issue("R3 mrs bank open", P_MRS, 2'd0, 1'b0, 2, 1);
    closeAll();
    issue("R3 mrs", P_MRS, 2'd0, 1'b0, 2, 0);
    issue("R4 act in lockout", P_ACT, 2'd0, 1'b0, 7, 1);
    issue("R4 act after lockout", P_ACT, 2'd0, 1'b0, 7, 0);
    closeAll();
    issue("R3 emrs", P_MRS, 2'd2, 1'b0, 3, 0);
    issue("R4 nop in lockout", P_NOP, 2'd0, 1'b0, 0, 0);
    issue("R4 act after nop", P_ACT, 2'd1, 1'b0, 7, 0);
    closeAll();
  endtask

  task automatic t_refresh();
    issue("R5 act b1", P_ACT, 2'd1, 1'b0, 7, 0);
    issue("R5 ref bank open", P_REF, 2'd0, 1'b0, 4, 1);
    closeAll();
    issue("R5 auto refresh", P_REF, 2'd0, 1'b0, 4, 0);
    cke = 1'b0;
    issue("R5 self ref entry", P_REF, 2'd0, 1'b0, 5, 0);
    issue("R2 act ignored cke low", P_ACT, 2'd0, 1'b0, 0, 0);
    cke = 1'b1;
    issue("R5 self ref exit", P_NOP, 2'd0, 1'b0, 6, 0);
    issue("R2 bank0 still idle", P_ACT, 2'd0, 1'b0, 7, 0);
    closeAll();
  endtask

  task automatic t_autopre();
    issue("R9 act b3", P_ACT, 2'd3, 1'b0, 7, 0);
    issue("R9 read ap", P_RD, 2'd3, 1'b1, 8, 0);
    check("R9 read ap flag", cmdAutoPre, 1);
    issue("R9 read in burst", P_RD, 2'd3, 1'b0, 8, 1);
    issue("R10 bst in ap burst", P_BST, 2'd0, 1'b0, 10, 0);
    issue("R9 nop", P_NOP, 2'd0, 1'b0, 0, 0);
    issue("R9 read after burst", P_RD, 2'd3, 1'b0, 8, 1);
    issue("R9 act before tRP", P_ACT, 2'd3, 1'b0, 7, 1);
    issue("R9 act at BL+tRP", P_ACT, 2'd3, 1'b0, 7, 0);
    issue("R9 write ap", P_WR, 2'd3, 1'b1, 9, 0);
    issue("R9 write in burst", P_WR, 2'd3, 1'b0, 9, 1);
    for (int i = 0; i < BL + TRP; i++) issue("R2 nop", P_NOP, 2'd0, 1'b0, 0, 0);
  endtask

  task automatic t_dqm();
    dqm = 1'b1; #1;
    check("R11 wrMask same cycle", wrMaskEn, 1);
    step();
    check("R12 rdHiZ not yet", rdHiZEn, 0);
    dqm = 1'b0; #1;
    check("R11 wrMask drops", wrMaskEn, 0);
    step();
    check("R12 rdHiZ high", rdHiZEn, 1);
    step();
    check("R12 rdHiZ released", rdHiZEn, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rstN = 1'b1;
    step();
    check("R13 after reset code", cmdCode, 0);
    t_decode();
    t_precharge();
    t_mrs();
    t_refresh();
    t_autopre();
    t_dqm();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule